// File: doc/BRIEF.md
# DDR SDRAM Command and Bank-State Tracker

This block watches the command pins of a four-bank DDR SDRAM interface, either on the controller side or as a behavioural checker beside a memory model. It samples chip select, the three command strobes, clock enable, the bank bits and a 12-bit address on every rising clock edge. From these it decodes the command and keeps, for each bank, whether a row is open and which row that is. It also follows the low-power modes that clock enable selects and flags command sequences that are not legal.

The tracker stores the two mode register values written by mode register set commands. It reports the current power mode, and it pulses an error output for one cycle after any illegal command or clock-enable transition. Data transfer, refresh timing and detailed timing checks are left to other blocks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is taken from {ras_n, cas_n, we_n}: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop. With cs_n high the sampled command has no effect on any output.
- R2: Activate to an idle bank selected by ba marks it open and stores addr as its row. Activate to an open bank raises err and leaves that bank's flag and row unchanged.
- R3: Read or write to an open bank keeps it open when addr[10] is 0 and closes it when addr[10] is 1. Read or write to an idle bank raises err and changes no bank.
- R4: Precharge with addr[10] at 0 closes only bank ba. With addr[10] at 1 it closes all banks. Precharge never raises err.
- R5: Mode register set with all banks idle loads addr into mr_base when ba is 0 and into mr_ext when ba is 1. It loads nothing when ba is 2 or 3. With any bank open it raises err and loads nothing.
- R6: Refresh with cke high while any bank is open raises err.
- R7: In normal mode (code 0), cke sampled low, except as a self-refresh entry, enters precharge power-down (code 1) when all banks are idle and active power-down (code 2) when any bank is open. No command has an effect while the block is in a low-power mode.
- R8: Refresh sampled with cke low in normal mode enters self-refresh (code 3) when all banks are idle. When a row is open it raises err and enters active power-down instead. In any low-power mode, cke sampled high returns the block to normal mode in the next cycle, and a command sampled at that same edge is ignored.
- R9: cke sampled low at either of the two edges after an accepted read or write raises err. From the third edge on, cke low raises no err.
- R10: Every output changes in the cycle after the edge that sampled its cause, and err is high for exactly that one cycle. After reset, all banks are idle, all rows are 0, the mode is 0, both mode registers are 0 and err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column and auto-precharge bit, or mode opcode |
| bank_active | output | 4 | Open flag per bank |
| open_row | output | 48 | Open row per bank, bank i at bits 12*i+11 : 12*i |
| mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| mr_base | output | 12 | Last value loaded into the base mode register |
| mr_ext | output | 12 | Last value loaded into the extended mode register |
| err | output | 1 | One-cycle pulse after an illegal sequence |

## Verification
Every result, including bank flags, rows, mode, mode registers and the err pulse, is due exactly one clock after the edge that sampled its cause. The bench drives on the falling edge, lets the reference model step at the rising edge, and compares all outputs at the next falling edge. The access window of R9 is probed at one, two and three edges after a read, so that the last edge with err and the first edge without it are both checked.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
   // command code is {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      C_MRS = 3'b000,
      C_REF = 3'b001,
      C_PRE = 3'b010,
      C_ACT = 3'b011,
      C_WR  = 3'b100,
      C_RD  = 3'b101,
      C_BST = 3'b110,
      C_NOP = 3'b111
   } cmd_t;

   typedef enum logic [1:0] {
      M_NORM = 2'd0,
      M_PPD  = 2'd1,
      M_APD  = 2'd2,
      M_SREF = 2'd3
   } pmode_t;
endpackage

// File: rtl/trk_decode.sv
module trk_decode
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 cmd_en,
   input  cmd_t                 cmd,
   input  logic [BA_W-1:0]      ba,
   input  logic                 ap,
   input  logic [NUM_BANKS-1:0] bank_active,
   output logic [NUM_BANKS-1:0] open_req,
   output logic [NUM_BANKS-1:0] close_req,
   output logic                 acc_start,
   output logic                 ld_base,
   output logic                 ld_ext,
   output logic                 err_cmd
);
   logic [NUM_BANKS-1:0] sel;
   logic                 any_open;
   logic                 tgt_open;

   assign sel      = NUM_BANKS'(1) << ba;
   assign any_open = |bank_active;
   assign tgt_open = bank_active[ba];

   always_comb begin
      open_req  = '0;
      close_req = '0;
      acc_start = 1'b0;
      ld_base   = 1'b0;
      ld_ext    = 1'b0;
      err_cmd   = 1'b0;
      if (cmd_en) begin
         unique case (cmd)
            C_ACT: begin
               if (tgt_open) err_cmd = 1'b1;
               else          open_req = sel;
            end
            C_RD, C_WR: begin
               if (!tgt_open) err_cmd = 1'b1;
               else begin
                  acc_start = 1'b1;
                  if (ap) close_req = sel;
               end
            end
            C_PRE: close_req = ap ? {NUM_BANKS{1'b1}} : sel;
            C_REF: err_cmd = any_open;
            C_MRS: begin
               if (any_open) err_cmd = 1'b1;
               else begin
                  ld_base = (ba == BA_W'(0));
                  ld_ext  = (ba == BA_W'(1));
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/trk_bank.sv
module trk_bank #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_req,
   input  logic             close_req,
   input  logic [ROW_W-1:0] row_in,
   output logic             active,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         row    <= '0;
      end else if (open_req) begin
         active <= 1'b1;
         row    <= row_in;
      end else if (close_req) begin
         active <= 1'b0;
      end
   end
endmodule

// File: rtl/trk_power.sv
module trk_power
   import sdram_trk_pkg::*;
#(
   parameter int ACC_CYC = 2,
   localparam int ACW    = $clog2(ACC_CYC + 1)
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cke,
   input  logic   self_req,
   input  logic   any_open,
   input  logic   acc_start,
   output pmode_t mode,
   output logic   in_norm,
   output logic   err_pwr
);
   logic [ACW-1:0] acc_cnt;
   logic           dropping;

   assign in_norm  = (mode == M_NORM);
   assign dropping = in_norm && !cke;
   assign err_pwr  = dropping && ((acc_cnt != '0) || (self_req && any_open));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= M_NORM;
         acc_cnt <= '0;
      end else if (in_norm) begin
         if (!cke) begin
            acc_cnt <= '0;
            if (self_req && !any_open) mode <= M_SREF;
            else if (any_open)         mode <= M_APD;
            else                       mode <= M_PPD;
         end else if (acc_start) begin
            acc_cnt <= ACW'(ACC_CYC);
         end else if (acc_cnt != '0) begin
            acc_cnt <= acc_cnt - 1'b1;
         end
      end else if (cke) begin
         mode <= M_NORM;
      end
   end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int AP_BIT    = 10,
   parameter int ACC_CYC   = 2,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic                       cke,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   output logic [NUM_BANKS-1:0]       bank_active,
   output logic [NUM_BANKS*ROW_W-1:0] open_row,
   output logic [1:0]                 mode,
   output logic [ROW_W-1:0]           mr_base,
   output logic [ROW_W-1:0]           mr_ext,
   output logic                       err
);
   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ROW_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address");
   end
   if (ACC_CYC < 1) begin : g_bad_acc
      $error("ACC_CYC must be at least 1");
   end

   cmd_t                 cmd;
   pmode_t               pmode;
   logic                 in_norm, cmd_en, self_req;
   logic [NUM_BANKS-1:0] open_req, close_req;
   logic                 acc_start, ld_base, ld_ext, err_cmd, err_pwr;

   assign cmd      = cmd_t'({ras_n, cas_n, we_n});
   assign cmd_en   = in_norm && cke && !cs_n;
   assign self_req = !cs_n && (cmd == C_REF);
   assign mode     = pmode;

   trk_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .cmd_en(cmd_en), .cmd(cmd), .ba(ba), .ap(addr[AP_BIT]),
      .bank_active(bank_active), .open_req(open_req), .close_req(close_req),
      .acc_start(acc_start), .ld_base(ld_base), .ld_ext(ld_ext), .err_cmd(err_cmd)
   );

   trk_power #(.ACC_CYC(ACC_CYC)) u_pwr (
      .clk(clk), .rst_n(rst_n), .cke(cke), .self_req(self_req),
      .any_open(|bank_active), .acc_start(acc_start),
      .mode(pmode), .in_norm(in_norm), .err_pwr(err_pwr)
   );

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      trk_bank #(.ROW_W(ROW_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .open_req(open_req[i]), .close_req(close_req[i]),
         .row_in(addr), .active(bank_active[i]), .row(open_row[i*ROW_W +: ROW_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mr_base <= '0;
         mr_ext  <= '0;
         err     <= 1'b0;
      end else begin
         if (ld_base) mr_base <= addr;
         if (ld_ext)  mr_ext  <= addr;
         err <= err_cmd | err_pwr;
      end
   end
endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_n,
   input logic                       ras_n,
   input logic                       cas_n,
   input logic                       we_n,
   input logic                       cke,
   input logic [BA_W-1:0]            ba,
   input logic [NUM_BANKS-1:0]       bank_active,
   input logic [NUM_BANKS*ROW_W-1:0] open_row,
   input logic [1:0]                 mode,
   input logic [ROW_W-1:0]           mr_base,
   input logic [ROW_W-1:0]           mr_ext,
   input logic                       err
);
   logic sref_cmd;
   assign sref_cmd = !cs_n && ({ras_n, cas_n, we_n} == 3'b001);

   AST_CS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cke && mode == 2'd0) |=> ($stable(bank_active) && $stable(open_row)
         && $stable(mr_base) && $stable(mr_ext) && !err)); // R1

   AST_ACT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && cke && !cs_n && {ras_n, cas_n, we_n} == 3'b011 && bank_active[ba])
         |=> err); // R2

   AST_IDLE_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !cke && bank_active == '0 && !sref_cmd) |=> mode == 2'd1); // R7

   AST_OPEN_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !cke && bank_active != '0) |=> mode == 2'd2); // R7

   AST_LOWPWR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0) |=> ($stable(bank_active) && $stable(mr_base) && $stable(mr_ext))); // R7

   AST_WAKE_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && cke) |=> mode == 2'd0); // R8

   AST_SREF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |-> bank_active == '0); // R8

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (err && mode != 2'd0) |=> !err); // R10
endmodule

bind sdram_cmd_tracker trk_checker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .cke(cke), .ba(ba), .bank_active(bank_active), .open_row(open_row), .mode(mode),
   .mr_base(mr_base), .mr_ext(mr_ext), .err(err)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;
   localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                          PRE = 3'b010, REF = 3'b001, MRS = 3'b000, BST = 3'b110;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic [3:0]  bank_active;
   logic [47:0] open_row;
   logic [1:0]  mode;
   logic [11:0] mr_base, mr_ext;
   logic        err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   sdram_cmd_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .ba(ba), .addr(addr), .bank_active(bank_active), .open_row(open_row),
      .mode(mode), .mr_base(mr_base), .mr_ext(mr_ext), .err(err)
   );

   // reference model
   bit   [3:0]  m_act;
   logic [11:0] m_row [4];
   int          m_mode;
   logic [11:0] m_mb, m_me;
   bit          m_err;
   int          m_acc;

   always @(posedge clk) begin
      bit e, any, sref;
      int b;
      e = 0;
      any = (m_act != 0);
      b = int'(ba);
      if (!rst_n) begin
         m_act = 0; m_mode = 0; m_mb = 0; m_me = 0; m_acc = 0;
         for (int i = 0; i < 4; i++) m_row[i] = 0;
      end else if (m_mode == 0) begin
         if (!cke) begin
            sref = !cs_n && {ras_n, cas_n, we_n} == REF;
            if (m_acc > 0) e = 1;
            if (sref && !any) m_mode = 3;
            else if (any) begin m_mode = 2; if (sref) e = 1; end
            else m_mode = 1;
            m_acc = 0;
         end else begin
            if (m_acc > 0) m_acc--;
            if (!cs_n) begin
               case ({ras_n, cas_n, we_n})
                  ACT: if (m_act[b]) e = 1; else begin m_act[b] = 1; m_row[b] = addr; end
                  RD, WR: if (!m_act[b]) e = 1; else begin
                     m_acc = 2;
                     if (addr[10]) m_act[b] = 0;
                  end
                  PRE: if (addr[10]) m_act = 0; else m_act[b] = 0;
                  REF: if (any) e = 1;
                  MRS: if (any) e = 1; else if (b == 0) m_mb = addr; else if (b == 1) m_me = addr;
                  default: ;
               endcase
            end
         end
      end else if (cke) m_mode = 0;
      m_err = rst_n ? e : 0;
   end

   task automatic compare(input string tag);
      logic [47:0] xr;
      for (int i = 0; i < 4; i++) xr[i*12 +: 12] = m_row[i];
      checks++;
      if (bank_active !== m_act || open_row !== xr || mode !== 2'(m_mode) ||
          mr_base !== m_mb || mr_ext !== m_me || err !== m_err) begin
         errors++;
         $display("FAIL %s act=%b row=%h mode=%0d mb=%h me=%h err=%b exp act=%b row=%h mode=%0d mb=%h me=%h err=%b",
                  tag, bank_active, open_row, mode, mr_base, mr_ext, err,
                  m_act, xr, m_mode, m_mb, m_me, m_err);
      end
   endtask

   task automatic step(input string tag, input logic c, input logic [2:0] k,
                       input logic e, input logic [1:0] b, input logic [11:0] a);
      cs_n = c; {ras_n, cas_n, we_n} = k; cke = e; ba = b; addr = a;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog R10 act=%0d exp=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R10 reset");
      rst_n = 1'b1;
      step("R10 nop", 0, NOP, 1, 0, 0);
      // R1: deselected commands
      step("R1 cs high act", 1, ACT, 1, 0, 12'h155);
      step("R1 cs high mrs", 1, MRS, 1, 0, 12'h3C3);
      // R5: mode register loads
      step("R5 base", 0, MRS, 1, 0, 12'h032);
      step("R5 ext", 0, MRS, 1, 1, 12'h001);
      step("R5 ba2 none", 0, MRS, 1, 2, 12'h7FF);
      step("R5 ba3 none", 0, MRS, 1, 3, 12'h5A5);
      // R2: activate
      step("R2 act b0", 0, ACT, 1, 0, 12'h123);
      step("R2 act b2", 0, ACT, 1, 2, 12'hABC);
      step("R2 act again", 0, ACT, 1, 0, 12'h777);
      step("R10 err clears", 0, BST, 1, 0, 0);
      // R3: accesses
      step("R3 rd idle", 0, RD, 1, 1, 0);
      step("R3 rd keep", 0, RD, 1, 0, 12'h010);
      step("R3 wr ap", 0, WR, 1, 2, 12'h410);
      // R6 / R5 with a row open
      step("R6 ref open", 0, REF, 1, 0, 0);
      step("R5 mrs open", 0, MRS, 1, 0, 12'h0FF);
      // R9: cke dropped right after a read
      step("R9 rd", 0, RD, 1, 0, 0);
      step("R9 drop early", 0, NOP, 0, 0, 0);
      step("R7 act ignored in pd", 0, ACT, 0, 1, 12'h222);
      step("R8 exit ignores act", 0, ACT, 1, 3, 12'h333);
      step("R8 normal", 0, NOP, 1, 0, 0);
      // R9: drop at second edge
      step("R9 rd2", 0, RD, 1, 0, 0);
      step("R9 gap1", 0, NOP, 1, 0, 0);
      step("R9 drop second", 0, NOP, 0, 0, 0);
      step("R8 exit", 0, NOP, 1, 0, 0);
      // R9: drop at third edge is legal
      step("R9 rd3", 0, RD, 1, 0, 0);
      step("R9 gap a", 0, NOP, 1, 0, 0);
      step("R9 gap b", 0, NOP, 1, 0, 0);
      step("R9 drop third", 0, NOP, 0, 0, 0);
      step("R8 exit2", 0, NOP, 1, 0, 0);
      // R4: precharge
      step("R4 pre b0", 0, PRE, 1, 0, 12'h000);
      step("R4 pre idle", 0, PRE, 1, 2, 12'h000);
      step("R2 act b1", 0, ACT, 1, 1, 12'h0F1);
      step("R2 act b3", 0, ACT, 1, 3, 12'hFF3);
      step("R4 pre all", 0, PRE, 1, 1, 12'h400);
      // R7: idle power-down
      step("R7 ppd", 0, NOP, 0, 0, 0);
      step("R7 ppd hold", 1, MRS, 0, 0, 12'h111);
      step("R8 exit ppd", 0, NOP, 1, 0, 0);
      step("R6 ref idle", 0, REF, 1, 0, 0);
      // R8: self refresh
      step("R8 sref", 0, REF, 0, 0, 0);
      step("R8 sref hold", 0, MRS, 0, 0, 12'h0AA);
      step("R8 sref exit", 0, NOP, 1, 0, 0);
      step("R2 act b1 again", 0, ACT, 1, 1, 12'h456);
      step("R8 sref open", 0, REF, 0, 0, 0);
      step("R8 apd exit", 0, NOP, 1, 0, 0);
      // R2: every bank open with its own row
      for (int i = 0; i < 4; i++)
         step("R2 fill", 0, ACT, 1, 2'(i), 12'h800 + 12'(i * 17));
      step("R4 pre b2 only", 0, PRE, 1, 2, 12'h3FF);
      step("R1 cs high pre all", 1, PRE, 1, 0, 12'h400);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule